// File: doc/BRIEF.md
# Nibble-Serial Debug Port Read Master

This block reads target memory through a four-bit synchronous debug port. It generates the port clock, which idles high. It drives an active-low frame strobe and an open-drain reset pull. The four-bit data lane is shared in both directions, using separate output, output-enable and input signals. After system reset the block runs a one-time mode-entry sequence on its own. After that it accepts single reads from a host. Each read returns either a byte or a 32-bit word, together with a one-cycle `done` pulse and an error flag.

Each read follows this framing:

1. Idle clock pulses with the strobe high.
2. The strobe drops, then a zero header nibble, a command nibble and eight address nibbles, least significant first.
3. The lane turns around and the block polls for a ready code, up to a bounded number of pulses. The strobe rises when polling ends.
4. On ready, the data nibbles are collected, most significant first.

A dump sequencer reuses this path. It issues byte reads from address zero upwards and stops on the first error or when its address counter wraps.

The main state machine has these states and transitions:

- BOOT goes to MODE_HOLD and asserts the reset pull.
- MODE_HOLD goes to MODE_REL after the hold pulses and releases the pull.
- MODE_REL goes to IDLE after the release pulses.
- IDLE goes to LEAD on an accepted start.
- LEAD goes to HDR after the lead pulses, with the strobe low.
- HDR goes to CMD.
- CMD goes to ADDR.
- ADDR goes to POLL after eight nibbles, with the output enable dropped.
- POLL goes to DATA on ready, or to FINISH on timeout.
- DATA goes to FINISH after the data nibbles.
- FINISH goes to IDLE, pulsing `done` and restoring the output enable.

The dump sequencer moves between D_IDLE, D_REQ and D_WAIT. D_REQ hands a read to the port engine. D_WAIT either steps back to D_REQ or ends in D_IDLE.

Top module: `nib_dbg_reader`

## Requirements
- R1: The port clock idles high. Each pulse is high for 2 time units, low for 1 unit and high for 2 units. One unit is `unit_div`+1 system clocks. Back-to-back pulses within a sequence start 5 units plus one clock apart.
- R2: After reset the reset pull is asserted (`port_rst_pull`=1) for exactly 10 clock pulses. It is then released for exactly 10 more pulses before `busy` falls.
- R3: A read begins with exactly 5 clock pulses while `port_sync_n` is high. The strobe then goes low.
- R4: With the strobe low, the first nibble clocked out is 0000. The second is the command: 1000 for a byte read (`rd_long`=0), 1010 for a word read (`rd_long`=1).
- R5: The address follows as 8 nibbles, one per pulse, bits [3:0] first and bits [31:28] last.
- R6: `port_dq_o` never changes while the port clock is low.
- R7: The output enable drops before the first poll pulse. Polling samples one nibble per pulse and stops at the first 0001, or after 10 pulses.
- R8: `port_sync_n` returns high when polling ends, on ready and on timeout alike. It stays high while the block is idle.
- R9: After ready, a byte read collects 2 nibbles and a word read 8, first nibble most significant. A byte result is zero-extended in `rd_data`.
- R10: On timeout no data pulses are issued. `done` comes with `err`=1 and `rd_data`=0.
- R11: `done` lasts one cycle. At that point the output enable is back on and `busy` is low. A start while busy changes neither the read in progress nor its result.
- R12: `dump_start` runs byte reads at addresses 0, 1, 2, … in order. The run ends after the read at address 2^`DUMP_W`−1, or after the first read that reports an error. Its end is marked by a one-cycle `dump_done` the cycle after that read's `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unit_div | input | DIV_W | Port time unit minus one, in system clocks |
| start | input | 1 | Host read request pulse |
| rd_addr | input | 32 | Host read address |
| rd_long | input | 1 | 1 selects a 32-bit read, 0 a byte read |
| dump_start | input | 1 | Starts the address dump sequence |
| rd_data | output | 32 | Result of the last read |
| done | output | 1 | One-cycle read completion pulse |
| err | output | 1 | Read ended on poll timeout (valid with done) |
| busy | output | 1 | Mode entry or read in progress |
| dump_busy | output | 1 | Dump sequence active |
| dump_done | output | 1 | One-cycle dump completion pulse |
| port_ck | output | 1 | Port clock |
| port_sync_n | output | 1 | Active-low frame strobe |
| port_rst_pull | output | 1 | 1 pulls the open-drain reset line low |
| port_dq_o | output | 4 | Data lane output value |
| port_dq_oe | output | 1 | Data lane output enable |
| port_dq_i | input | 4 | Data lane input value |

## Verification
The bench builds the block with `DUMP_W`=3, so a dump wraps after eight reads. That brings both the counter-wrap end and an error end of the dump within a short run. `DIV_W` is 4, with `unit_div` at 1 for most reads and 3 for one read, so pulse widths and spacings are checked at two unit lengths. The polling limit stays at its default of 10. This allows a vector that becomes ready on the tenth and last poll, next to vectors that time out.

// File: rtl/nibdbg_pkg.sv
package nibdbg_pkg;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_MODE_HOLD,
        ST_MODE_REL,
        ST_IDLE,
        ST_LEAD,
        ST_HDR,
        ST_CMD,
        ST_ADDR,
        ST_POLL,
        ST_DATA,
        ST_FINISH
    } rd_state_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PRE,
        PH_LOW,
        PH_POST
    } pulse_phase_t;

    typedef enum logic [1:0] {
        D_IDLE,
        D_REQ,
        D_WAIT
    } dump_state_t;

    localparam logic [3:0] NIB_HDR   = 4'b0000;
    localparam logic [3:0] NIB_BYTE  = 4'b1000;
    localparam logic [3:0] NIB_LONG  = 4'b1010;
    localparam logic [3:0] NIB_READY = 4'b0001;

endpackage

// File: rtl/nibdbg_tick.sv
module nibdbg_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == div);

endmodule

// File: rtl/nibdbg_pulse.sv
module nibdbg_pulse
    import nibdbg_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int PRE_UNITS   = 2,
    parameter int LOW_UNITS   = 1,
    parameter int POST_UNITS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DIV_W-1:0] div,
    output logic             pck,
    output logic             idle,
    output logic             done
);
    localparam int MAXU = (PRE_UNITS > POST_UNITS) ? PRE_UNITS : POST_UNITS;
    localparam int UW   = $clog2(MAXU + LOW_UNITS + 1);

    pulse_phase_t ph;
    logic [UW-1:0] ucnt;
    logic          tick;

    nibdbg_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ph != PH_IDLE),
        .div  (div),
        .tick (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph   <= PH_IDLE;
            ucnt <= '0;
            pck  <= 1'b1;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    if (go) begin
                        ph   <= PH_PRE;
                        ucnt <= '0;
                    end
                end
                PH_PRE: begin
                    if (tick) begin
                        if (ucnt == UW'(PRE_UNITS - 1)) begin
                            ph   <= PH_LOW;
                            ucnt <= '0;
                            pck  <= 1'b0;
                        end else begin
                            ucnt <= ucnt + 1'b1;
                        end
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (ucnt == UW'(LOW_UNITS - 1)) begin
                            ph   <= PH_POST;
                            ucnt <= '0;
                            pck  <= 1'b1;
                        end else begin
                            ucnt <= ucnt + 1'b1;
                        end
                    end
                end
                PH_POST: begin
                    if (tick) begin
                        if (ucnt == UW'(POST_UNITS - 1)) begin
                            ph   <= PH_IDLE;
                            ucnt <= '0;
                        end else begin
                            ucnt <= ucnt + 1'b1;
                        end
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign idle = (ph == PH_IDLE);
    assign done = (ph == PH_POST) && tick && (ucnt == UW'(POST_UNITS - 1));

    AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pck) |-> $past(tick)); // R1

    AST_IDLE_CK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> pck); // R1

endmodule

// File: rtl/nibdbg_dump.sv
module nibdbg_dump
    import nibdbg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DUMP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              rd_busy,
    input  logic              rd_done,
    input  logic              rd_err,
    output logic              req,
    output logic [ADDR_W-1:0] req_addr,
    output logic              active,
    output logic              finished
);
    dump_state_t       st;
    logic [DUMP_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= D_IDLE;
            cnt      <= '0;
            finished <= 1'b0;
        end else begin
            finished <= 1'b0;
            unique case (st)
                D_IDLE: begin
                    if (go && !rd_busy) begin
                        st  <= D_REQ;
                        cnt <= '0;
                    end
                end
                D_REQ: begin
                    if (!rd_busy) st <= D_WAIT;
                end
                D_WAIT: begin
                    if (rd_done) begin
                        if (rd_err || (&cnt)) begin
                            st       <= D_IDLE;
                            finished <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                            st  <= D_REQ;
                        end
                    end
                end
                default: st <= D_IDLE;
            endcase
        end
    end

    assign req      = (st == D_REQ) && !rd_busy;
    assign req_addr = ADDR_W'(cnt);
    assign active   = (st != D_IDLE);

    AST_DUMP_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && $past(rd_busy)) |-> $stable(cnt)); // R12

    AST_DUMP_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        finished |=> !finished); // R12

endmodule

// File: rtl/nib_dbg_reader.sv
module nib_dbg_reader
    import nibdbg_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int MODE_PULSES = 10,
    parameter int LEAD_PULSES = 5,
    parameter int POLL_LIMIT  = 10,
    parameter int DUMP_W      = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [DIV_W-1:0] unit_div,
    input  logic        start,
    input  logic [31:0] rd_addr,
    input  logic        rd_long,
    input  logic        dump_start,
    output logic [31:0] rd_data,
    output logic        done,
    output logic        err,
    output logic        busy,
    output logic        dump_busy,
    output logic        dump_done,
    output logic        port_ck,
    output logic        port_sync_n,
    output logic        port_rst_pull,
    output logic [3:0]  port_dq_o,
    output logic        port_dq_oe,
    input  logic [3:0]  port_dq_i
);
    localparam int ADDR_W    = 32;
    localparam int ADDR_NIBS = ADDR_W / 4;
    localparam int BYTE_NIBS = 2;
    localparam int LONG_NIBS = 8;
    localparam int CNT_SPAN  = MODE_PULSES + LEAD_PULSES + POLL_LIMIT + ADDR_NIBS + LONG_NIBS;
    localparam int CNT_W     = $clog2(CNT_SPAN + 1);

    rd_state_t          st, st_nx;
    logic [CNT_W-1:0]   cnt;
    logic [ADDR_W-1:0]  sh;
    logic [31:0]        acc;
    logic               long_q;
    logic               fail;

    logic               p_go, p_idle, p_done;
    logic               d_req;
    logic [ADDR_W-1:0]  d_addr;
    logic               start_eff;
    logic [ADDR_W-1:0]  addr_eff;
    logic               long_eff;
    logic               needs_pulse;
    logic               poll_ready;
    logic [CNT_W-1:0]   data_last;

    nibdbg_pulse #(.DIV_W(DIV_W)) u_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (p_go),
        .div  (unit_div),
        .pck  (port_ck),
        .idle (p_idle),
        .done (p_done)
    );

    nibdbg_dump #(.ADDR_W(ADDR_W), .DUMP_W(DUMP_W)) u_dump (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (dump_start),
        .rd_busy (busy),
        .rd_done (done),
        .rd_err  (err),
        .req     (d_req),
        .req_addr(d_addr),
        .active  (dump_busy),
        .finished(dump_done)
    );

    assign start_eff = dump_busy ? d_req  : start;
    assign addr_eff  = dump_busy ? d_addr : rd_addr;
    assign long_eff  = dump_busy ? 1'b0   : rd_long;

    assign busy       = (st != ST_IDLE);
    assign poll_ready = (port_dq_i == NIB_READY);
    assign data_last  = long_q ? CNT_W'(LONG_NIBS - 1) : CNT_W'(BYTE_NIBS - 1);

    always_comb begin
        unique case (st)
            ST_MODE_HOLD, ST_MODE_REL, ST_LEAD, ST_HDR,
            ST_CMD, ST_ADDR, ST_POLL, ST_DATA: needs_pulse = 1'b1;
            default:                           needs_pulse = 1'b0;
        endcase
    end

    assign p_go = needs_pulse && p_idle;

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_BOOT:      st_nx = ST_MODE_HOLD;
            ST_MODE_HOLD: if (p_done && cnt == CNT_W'(MODE_PULSES - 1)) st_nx = ST_MODE_REL;
            ST_MODE_REL:  if (p_done && cnt == CNT_W'(MODE_PULSES - 1)) st_nx = ST_IDLE;
            ST_IDLE:      if (start_eff) st_nx = ST_LEAD;
            ST_LEAD:      if (p_done && cnt == CNT_W'(LEAD_PULSES - 1)) st_nx = ST_HDR;
            ST_HDR:       if (p_done) st_nx = ST_CMD;
            ST_CMD:       if (p_done) st_nx = ST_ADDR;
            ST_ADDR:      if (p_done && cnt == CNT_W'(ADDR_NIBS - 1)) st_nx = ST_POLL;
            ST_POLL: begin
                if (p_done) begin
                    if (poll_ready)                            st_nx = ST_DATA;
                    else if (cnt == CNT_W'(POLL_LIMIT - 1))    st_nx = ST_FINISH;
                end
            end
            ST_DATA:      if (p_done && cnt == data_last) st_nx = ST_FINISH;
            ST_FINISH:    st_nx = ST_IDLE;
            default:      st_nx = ST_BOOT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_BOOT;
        else        st <= st_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt           <= '0;
            sh            <= '0;
            acc           <= '0;
            long_q        <= 1'b0;
            fail          <= 1'b0;
            rd_data       <= '0;
            done          <= 1'b0;
            err           <= 1'b0;
            port_sync_n   <= 1'b1;
            port_rst_pull <= 1'b0;
            port_dq_o     <= NIB_HDR;
            port_dq_oe    <= 1'b1;
        end else begin
            done <= 1'b0;
            if (st_nx != st)  cnt <= '0;
            else if (p_done)  cnt <= cnt + 1'b1;

            unique case (st)
                ST_BOOT: port_rst_pull <= 1'b1;
                ST_MODE_HOLD: begin
                    if (st_nx == ST_MODE_REL) port_rst_pull <= 1'b0;
                end
                ST_MODE_REL: ;
                ST_IDLE: begin
                    if (start_eff) begin
                        sh     <= addr_eff;
                        long_q <= long_eff;
                        acc    <= '0;
                        fail   <= 1'b0;
                    end
                end
                ST_LEAD: begin
                    if (st_nx == ST_HDR) begin
                        port_sync_n <= 1'b0;
                        port_dq_o   <= NIB_HDR;
                    end
                end
                ST_HDR: begin
                    if (p_done) port_dq_o <= long_q ? NIB_LONG : NIB_BYTE;
                end
                ST_CMD: begin
                    if (p_done) begin
                        port_dq_o <= sh[3:0];
                        sh        <= sh >> 4;
                    end
                end
                ST_ADDR: begin
                    if (p_done) begin
                        if (st_nx == ST_POLL) begin
                            port_dq_oe <= 1'b0;
                            port_dq_o  <= NIB_HDR;
                        end else begin
                            port_dq_o <= sh[3:0];
                            sh        <= sh >> 4;
                        end
                    end
                end
                ST_POLL: begin
                    if (st_nx != ST_POLL) begin
                        port_sync_n <= 1'b1;
                        fail        <= !poll_ready;
                    end
                end
                ST_DATA: begin
                    if (p_done) acc <= {acc[27:0], port_dq_i};
                end
                ST_FINISH: begin
                    done       <= 1'b1;
                    err        <= fail;
                    rd_data    <= fail ? '0 : acc;
                    port_dq_oe <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (rd_data == 32'h0)); // R10

    AST_DQ_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !port_ck |-> $stable(port_dq_o)); // R6

    AST_TURN_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !port_dq_oe |-> !port_rst_pull); // R7

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_POLL) |-> (cnt < CNT_W'(POLL_LIMIT))); // R7

    AST_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> port_sync_n); // R8

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(long_q)); // R11

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && port_dq_oe)); // R11

endmodule

// File: tb/sim_nib_dbg_reader.sv
module sim_nib_dbg_reader;
    localparam int DIV_W  = 4;
    localparam int DUMP_W = 3;
    localparam int NV     = 6;

    localparam logic [31:0] V_ADDR [NV] = '{32'h1234_5678, 32'hA5F0_0F5A, 32'hFFFF_FFFF,
                                            32'h0000_0010, 32'h8000_0001, 32'h0F0F_0F0F};
    localparam logic        V_LONG [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam int          V_WAIT [NV] = '{0, 3, 9, 10, 1, 10};
    localparam logic [31:0] V_DATA [NV] = '{32'h0000_00C3, 32'hDEAD_BEEF, 32'h0000_007E,
                                            32'h1111_1111, 32'h0123_4567, 32'h0000_0099};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n;
    logic [DIV_W-1:0] unit_div;
    logic             start, rd_long, dump_start;
    logic [31:0]      rd_addr, rd_data;
    logic             done, err, busy, dump_busy, dump_done;
    logic             ck, sync_n, rst_pull, oe;
    logic [3:0]       dq_o, dq_i;

    nib_dbg_reader #(.DIV_W(DIV_W), .DUMP_W(DUMP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .unit_div(unit_div), .start(start), .rd_addr(rd_addr),
        .rd_long(rd_long), .dump_start(dump_start), .rd_data(rd_data), .done(done), .err(err),
        .busy(busy), .dump_busy(dump_busy), .dump_done(dump_done), .port_ck(ck),
        .port_sync_n(sync_n), .port_rst_pull(rst_pull), .port_dq_o(dq_o), .port_dq_oe(oe),
        .port_dq_i(dq_i)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // target model and port monitor
    logic [3:0]  sent [16];
    int          sent_n, lead_n, poll_n, data_n, lo_rise, rel_rise, k;
    int          low_len, low_bad, gap_cnt, gap_bad, dq_chg, cur_u;
    bit          have_fall, boot, dump_mode, m_long;
    logic        prev_ck, prev_oe, prev_sync;
    logic [3:0]  prev_dq;
    logic [31:0] m_addr, m_data, fail_addr;
    int          m_wait;

    function automatic logic [3:0] nib_at(input int idx);
        int j;
        if (m_wait >= 10 || idx < m_wait) return 4'h5;
        if (idx == m_wait) return 4'h1;
        j = idx - m_wait - 1;
        if (m_long) return m_data[31 - 4*j -: 4];
        return m_data[7 - 4*j -: 4];
    endfunction

    function automatic logic [7:0] dump_byte(input logic [31:0] a);
        return 8'(a * 29 + 64);
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_ck = 1'b1; prev_oe = 1'b1; prev_sync = 1'b1; prev_dq = 4'h0;
            boot = 1'b1; have_fall = 1'b0; low_len = 0; gap_cnt = 0;
        end else begin
            if (!ck) low_len++;
            gap_cnt++;
            if (!prev_ck && ck) begin
                if (low_len != cur_u) low_bad++;
                low_len = 0;
                if (rst_pull)               lo_rise++;
                else if (boot)              rel_rise++;
                else if (oe && sync_n)      lead_n++;
                else if (oe && !sync_n) begin
                    if (sent_n < 16) sent[sent_n] = dq_o;
                    sent_n++;
                end
                else if (!sync_n)           poll_n++;
                else                        data_n++;
            end
            if (prev_ck && !ck) begin
                if (have_fall && gap_cnt != 5*cur_u + 1) gap_bad++;
                have_fall = 1'b1;
                gap_cnt = 0;
                if (!oe) begin
                    dq_i = nib_at(k);
                    k++;
                end
            end
            if (!busy) have_fall = 1'b0;
            if (!ck && dq_o != prev_dq) dq_chg++;
            if (prev_sync && !sync_n) begin
                sent_n = 0; poll_n = 0; data_n = 0;
            end
            if (prev_oe && !oe) begin
                for (int i = 0; i < 8; i++) m_addr[4*i +: 4] = sent[2+i];
                k = 0;
                if (dump_mode) begin
                    m_long = 1'b0;
                    m_data = {24'h0, dump_byte(m_addr)};
                    m_wait = (m_addr == fail_addr) ? 10 : int'(m_addr % 3);
                end
            end
            if (boot && !busy) boot = 1'b0;
            prev_ck = ck; prev_oe = oe; prev_sync = sync_n; prev_dq = dq_o;
        end
    end

    task automatic pulse_start(input logic [31:0] a, input logic lng);
        @(negedge clk);
        rd_addr = a; rd_long = lng; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
        if (!ok) chk(1'b0, "timeout waiting for done", 32'h0, 32'h1);
    endtask

    task automatic check_read(input logic [31:0] a, input logic lng, input int w,
                              input logic [31:0] d);
        logic [31:0] exp;
        bit          e;
        e   = (w >= 10);
        exp = e ? 32'h0 : (lng ? d : {24'h0, d[7:0]});
        chk(lead_n == 5, "R3 lead pulses", lead_n, 5);
        chk(sent_n == 10, "R5 nibbles sent", sent_n, 10);
        chk(sent[0] == 4'h0, "R4 header nibble", sent[0], 0);
        chk(sent[1] == (lng ? 4'hA : 4'h8), "R4 command nibble", sent[1], lng ? 4'hA : 4'h8);
        chk(m_addr == a, "R5 address order", m_addr, a);
        chk(poll_n == (e ? 10 : w + 1), "R7 poll pulses", poll_n, e ? 10 : w + 1);
        chk(data_n == (e ? 0 : (lng ? 8 : 2)), "R9 R10 data pulses", data_n, e ? 0 : (lng ? 8 : 2));
        chk(rd_data == exp, "R9 R10 read data", rd_data, exp);
        chk(err == e, "R10 error flag", err, e);
        chk(oe && sync_n && !busy, "R8 R11 lines at done", {oe, sync_n, busy}, 3'b110);
        @(negedge clk);
        chk(!done, "R11 done single cycle", done, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit ok;
        int n;
        logic [31:0] exp;
        rst_n = 1'b0; unit_div = 4'd1; cur_u = 2; start = 1'b0; dump_start = 1'b0;
        rd_addr = 32'h0; rd_long = 1'b0; dq_i = 4'h0;
        sent_n = 0; lead_n = 0; poll_n = 0; data_n = 0; lo_rise = 0; rel_rise = 0; k = 0;
        low_bad = 0; gap_bad = 0; dq_chg = 0; dump_mode = 1'b0; m_long = 1'b0;
        m_addr = 32'h0; m_data = 32'h0; m_wait = 0; fail_addr = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        // reset state
        chk(ck == 1'b1, "R1 clock idles high", ck, 1);
        chk(sync_n == 1'b1, "R8 strobe high in reset", sync_n, 1);
        chk(rst_pull == 1'b0, "R2 pull off in reset", rst_pull, 0);
        chk(oe == 1'b1 && done == 1'b0, "R11 reset outputs", {oe, done}, 2'b10);
        rst_n = 1'b1;

        // mode entry
        n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
        chk(lo_rise == 10, "R2 hold pulses", lo_rise, 10);
        chk(rel_rise == 10, "R2 release pulses", rel_rise, 10);
        chk(!rst_pull && ck, "R2 R1 idle after entry", {rst_pull, ck}, 2'b01);

        // table of reads
        for (int v = 0; v < NV; v++) begin
            m_long = V_LONG[v]; m_data = V_DATA[v]; m_wait = V_WAIT[v];
            lead_n = 0;
            pulse_start(V_ADDR[v], V_LONG[v]);
            wait_done(ok);
            if (ok) check_read(V_ADDR[v], V_LONG[v], V_WAIT[v], V_DATA[v]);
        end

        // start while busy is ignored (R11)
        m_long = 1'b1; m_data = 32'h600D_F00D; m_wait = 2; lead_n = 0;
        pulse_start(32'h1357_9BDF, 1'b1);
        repeat (60) @(negedge clk);
        pulse_start(32'hFFFF_0000, 1'b0);
        wait_done(ok);
        if (ok) check_read(32'h1357_9BDF, 1'b1, 2, 32'h600D_F00D);

        // longer unit (R1)
        unit_div = 4'd3; cur_u = 4;
        m_long = 1'b0; m_data = 32'h0000_005A; m_wait = 4; lead_n = 0;
        pulse_start(32'h0000_0BAD, 1'b0);
        wait_done(ok);
        if (ok) check_read(32'h0000_0BAD, 1'b0, 4, 32'h0000_005A);
        unit_div = 4'd1; cur_u = 2;

        // dump runs to wrap, then dump ending on error (R12)
        for (int run = 0; run < 2; run++) begin
            dump_mode = 1'b1;
            fail_addr = (run == 0) ? 32'hFFFF_FFFF : 32'h3;
            @(negedge clk); dump_start = 1'b1;
            @(negedge clk); dump_start = 1'b0;
            n = 0;
            for (int c = 0; c < 60000; c++) begin
                if (done) begin
                    exp = (m_addr == fail_addr) ? 32'h0 : {24'h0, dump_byte(m_addr)};
                    chk(m_addr == n, "R12 dump address step", m_addr, n);
                    chk(rd_data == exp, "R12 dump data", rd_data, exp);
                    chk(err == (m_addr == fail_addr), "R12 dump error flag", err, m_addr == fail_addr);
                    n++;
                end
                if (dump_done) break;
                @(negedge clk);
            end
            chk(n == ((run == 0) ? 8 : 4), "R12 dump read count", n, (run == 0) ? 8 : 4);
            chk(dump_done && !dump_busy, "R12 dump end", {dump_done, dump_busy}, 2'b10);
            @(negedge clk);
            chk(!dump_done, "R12 dump_done single cycle", dump_done, 0);
        end

        chk(low_bad == 0, "R1 low phase width", low_bad, 0);
        chk(gap_bad == 0, "R1 pulse spacing", gap_bad, 0);
        chk(dq_chg == 0, "R6 data stable while clock low", dq_chg, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule